// File: doc/BRIEF.md
# Key-Protected RAM Erase Controller

This block guards a hardware command that wipes a RAM. The wipe start bit in a control/status register can only be set once software has written a two-byte unlock sequence to an 8-bit key register. A wrong key value locks the block again.

When the start is accepted, an erase engine drives the RAM write port and stores zero at every address, one word per clock. Both the start bit and a busy bit read back high while the wipe runs. The start bit clears itself when the last word has been written. An accepted start also re-locks the key, so every wipe needs a fresh unlock sequence.

Software reaches the block through a synchronous register port. A write takes effect on the clock edge at which `reg_we` is high. Read data is combinational from `reg_addr`.

Top module: `ram_wipe_ctrl`

## Requirements
- R1: After reset, `busy` and `ram_we` are 0, the control/status register (byte offset 28) reads 0, and the key is locked.
- R2: Two writes to the key register (byte offset 32) unlock the block: first 0xCA, then 0x53. A following write to offset 28 with bit 0 set starts a wipe.
- R3: After 0xCA, any second key value other than 0x53 locks the block again, and a following start write is ignored. A wrong value written after a full unlock also locks the block again.
- R4: A start write is ignored when no key was written. It is also ignored when 0x53 was written without a 0xCA before it. A first key value other than 0xCA, followed by 0x53, does not unlock.
- R5: Writing 0xCA while the first key is pending restarts the sequence. The writes 0xCA, 0xCA, 0x53 unlock the block.
- R6: A wipe writes zero to addresses 0 through DEPTH-1 in increasing order, one address per cycle. `ram_we` is high for exactly DEPTH cycles, starting in the cycle after the edge that accepts the start write.
- R7: During a wipe, control/status bit 0 (start) and bit 1 (busy) both read 1. Both read 0 in the cycle after the last RAM write.
- R8: An accepted start locks the key again. A second start write with no new key sequence is ignored.
- R9: A start write during a wipe has no effect, even when the block has been unlocked again. The wipe still ends after DEPTH writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | $clog2(DEPTH) | RAM write address |
| ram_wdata | output | DATA_W | RAM write data (always zero) |
| busy | output | 1 | Wipe in progress |

## Verification
The bench builds the block with DEPTH=8 and DATA_W=16. With that depth, every wipe can be followed word by word, including the drop of busy after the eighth write. The short wipes make a full sweep practical. The bench tries all 256 values as the second key after 0xCA, and all 256 values as the first key before 0x53. These sweeps reach the restart on a repeated 0xCA and every wrong-key path.

// File: rtl/ram_wipe_pkg.sv
package ram_wipe_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_FIRST  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  // Next key state for one write of value v.
  function automatic key_state_e key_step(key_state_e cur, logic [7:0] v);
    if (v == KEY_FIRST) return KS_FIRST;
    if (v == KEY_SECOND && cur == KS_FIRST) return KS_OPEN;
    return KS_LOCKED;
  endfunction

endpackage

// File: rtl/wipe_key_fsm.sv
module wipe_key_fsm
  import ram_wipe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  input  logic       relock,
  output logic       unlocked
);

  key_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= KS_LOCKED;
    else if (key_wr)  state <= key_step(state, key_val);
    else if (relock)  state <= KS_LOCKED;
  end

  assign unlocked = (state == KS_OPEN);

  // R2: the block can only open right after a write of the second key value
  a_r2_open_after_second: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && key_val == KEY_SECOND));

  // R8: an accepted start leaves the key locked
  a_r8_relock_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (relock && !key_wr) |=> !unlocked);

endmodule

// File: rtl/wipe_engine.sv
module wipe_engine #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              last_evt
);

  function automatic logic at_end(logic [AW-1:0] a);
    return a == AW'(DEPTH - 1);
  endfunction

  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (at_end(cnt)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  assign last_evt  = busy && at_end(cnt);
  assign ram_we    = busy;
  assign ram_addr  = cnt;
  assign ram_wdata = '0;

  // R6: each wipe begins at address zero
  a_r6_first_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we) |-> ram_addr == '0);

  // R6: addresses rise by one each cycle until the last word
  a_r6_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !last_evt) |=> (ram_we && ram_addr == $past(ram_addr) + 1'b1));

  // R7, R9: busy drops right after the last write, whatever start does
  a_r7_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> !busy);

endmodule

// File: rtl/ram_wipe_ctrl.sv
module ram_wipe_ctrl #(
  parameter int DEPTH    = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 28,
  parameter int KEY_OFS  = 32,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              busy
);

  logic sel_ctrl, sel_key;
  logic ctrl_wr, key_wr;
  logic unlocked, start_go, last_evt;

  assign sel_ctrl = (reg_addr == ADDR_W'(CTRL_OFS));
  assign sel_key  = (reg_addr == ADDR_W'(KEY_OFS));
  assign ctrl_wr  = reg_we && sel_ctrl;
  assign key_wr   = reg_we && sel_key;
  assign start_go = ctrl_wr && reg_wdata[0] && unlocked && !busy;

  wipe_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_val  (reg_wdata),
    .relock   (start_go),
    .unlocked (unlocked)
  );

  wipe_engine #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_go),
    .busy      (busy),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .last_evt  (last_evt)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl) reg_rdata = {6'b0, busy, busy};
  end

  // R4: a wipe starts only from the unlocked state
  a_r4_start_only_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(unlocked));

  // R2: an accepted start raises busy on the next cycle
  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> busy);

  // R9: a start write during a wipe never restarts the address count
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_evt && ctrl_wr) |=> ram_addr != '0);

endmodule

// File: tb/ram_wipe_ctrl_test.sv
module ram_wipe_ctrl_test;

  localparam int DEPTH  = 8;
  localparam int DATA_W = 16;
  localparam int AW     = $clog2(DEPTH);
  localparam logic [7:0] OFS_CTRL = 8'd28;
  localparam logic [7:0] OFS_KEY  = 8'd32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [7:0]        reg_addr = 8'd0;
  logic [7:0]        reg_wdata = 8'd0;
  logic [7:0]        reg_rdata;
  logic              ram_we;
  logic [AW-1:0]     ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic              busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ram_wipe_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .busy(busy)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge; the write is captured at the next posedge.
  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = OFS_CTRL;
  endtask

  // Read the control/status register in the current cycle.
  function automatic int status();
    return int'(reg_rdata);
  endfunction

  // Just after the start write: follow a whole wipe. poke_at >= 0 writes start
  // again in that cycle of the wipe.
  task automatic follow_wipe(string req, int poke_at);
    for (int i = 0; i < DEPTH; i++) begin
      reg_addr = OFS_CTRL;
      #1;
      check(req, "ram_we during wipe", int'(ram_we), 1);
      check(req, "ram_addr order", int'(ram_addr), i);
      check(req, "ram_wdata zero", int'(ram_wdata), 0);
      check("R7", "status during wipe", status(), 3);
      if (i == poke_at) begin
        reg_wdata = 8'h01; reg_we = 1'b1;
      end
      @(negedge clk);
      reg_we = 1'b0;
    end
    #1;
    check(req, "ram_we after last word", int'(ram_we), 0);
    check("R7", "status after wipe", status(), 0);
    check("R7", "busy after wipe", int'(busy), 0);
  endtask

  task automatic expect_idle(string req);
    for (int i = 0; i < 3; i++) begin
      #1;
      check(req, "no wipe started", int'(ram_we), 0);
      check(req, "status idle", status(), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    reg_addr = OFS_CTRL;
    #1;
    check("R1", "busy at reset", int'(busy), 0);
    check("R1", "ram_we at reset", int'(ram_we), 0);
    check("R1", "status at reset", status(), 0);
    @(negedge clk);

    // R4: start without any key
    wr(OFS_CTRL, 8'h01);
    expect_idle("R4");
    // R4: second key alone
    wr(OFS_KEY, 8'h53);
    wr(OFS_CTRL, 8'h01);
    expect_idle("R4");

    // R2: basic unlock and wipe
    wr(OFS_KEY, 8'hCA);
    wr(OFS_KEY, 8'h53);
    wr(OFS_CTRL, 8'h01);
    follow_wipe("R2", -1);

    // R8: a second start with no new key is ignored
    wr(OFS_CTRL, 8'h01);
    expect_idle("R8");

    // R3: a wrong value after a full unlock locks again
    wr(OFS_KEY, 8'hCA);
    wr(OFS_KEY, 8'h53);
    wr(OFS_KEY, 8'h77);
    wr(OFS_CTRL, 8'h01);
    expect_idle("R3");

    // R5: a repeated first key restarts the sequence
    wr(OFS_KEY, 8'hCA);
    wr(OFS_KEY, 8'hCA);
    wr(OFS_KEY, 8'h53);
    wr(OFS_CTRL, 8'h01);
    follow_wipe("R5", -1);

    // R9: unlock again during a wipe, then write start while busy
    wr(OFS_KEY, 8'hCA);
    wr(OFS_KEY, 8'h53);
    wr(OFS_CTRL, 8'h01);
    reg_addr = OFS_KEY; reg_wdata = 8'hCA; reg_we = 1'b1;
    #1;
    check("R9", "first wipe word", int'(ram_addr), 0);
    @(negedge clk);
    reg_wdata = 8'h53;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = OFS_CTRL;
    #1;
    check("R9", "wipe running at word 2", int'(ram_addr), 2);
    reg_wdata = 8'h01; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    for (int i = 3; i < DEPTH; i++) begin
      #1;
      check("R9", "address keeps counting", int'(ram_addr), i);
      @(negedge clk);
    end
    #1;
    check("R9", "wipe ends after DEPTH writes", int'(ram_we), 0);
    @(negedge clk);
    // The key opened during the wipe is still open: a start works now.
    wr(OFS_CTRL, 8'h01);
    follow_wipe("R9", -1);

    // R3/R2 sweep: every second key value after 0xCA
    for (int v = 0; v < 256; v++) begin
      wr(OFS_KEY, 8'hCA);
      wr(OFS_KEY, 8'(v));
      wr(OFS_CTRL, 8'h01);
      if (v == 8'h53) follow_wipe("R2", -1);
      else if (v == 8'hCA) expect_idle("R5");
      else begin
        #1;
        check("R3", "wrong second key", int'(ram_we), 0);
        @(negedge clk);
      end
    end

    // R4/R5 sweep: every first key value before 0x53
    for (int v = 0; v < 256; v++) begin
      wr(OFS_KEY, 8'(v));
      wr(OFS_KEY, 8'h53);
      wr(OFS_CTRL, 8'h01);
      if (v == 8'hCA) follow_wipe("R5", 1);
      else begin
        #1;
        check("R4", "wrong first key", int'(ram_we), 0);
        @(negedge clk);
      end
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule